// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Increment Converters

This block adds two unsigned operands and a carry-in and returns the sum and the carry-out, purely combinationally. The operand width is a parameter; the widths 8, 16, 32 and 64 bits are the supported set. The bits are cut into slices of growing size: from the least significant end they are 2, 2, 3, 4, 5, 6, 7 and so on bits wide. The last slice is shortened so that the slice widths add up exactly to the operand width. With this schedule, 8 bits split as 2,2,3,1; 16 bits as 2,2,3,4,5; 32 bits as 2,2,3,4,5,6,7,3; and 64 bits as 2,2,3,4,5,6,7,8,9,10,8.

The lowest slice is a plain ripple adder fed by the external carry-in. Every higher slice has these parts:
- One ripple adder, which assumes an incoming carry of zero.
- An increment-by-one converter, which adds one to that slice's {carry, sum} result. This gives the result for an incoming carry of one without a second ripple adder.
- A two-way selector, which the carry leaving the slice below switches between the two candidates.

The carry that travels between slices therefore passes through one selector per slice. It does not ripple through every bit. Inside each slice, the two candidates are formed in parallel while the lower slices settle. The block is meant to sit inside a larger datapath wherever a single-cycle add is needed. It has no clock and no state.

Top module: `sqcs_adder`

## Requirements
- R1: With W=8, {cout, sum} equals a + b + cin for every one of the 2^17 combinations of a, b and cin.
- R2: With W=16, W=32 and W=64, {cout, sum} equals a + b + cin for arbitrary operand values, with cin either 0 or 1.
- R3: When a is all ones, b is zero and cin is 1, sum is all zeros and cout is 1. The carry crosses every slice boundary.
- R4: When a and b are both all ones, the result is sum = all ones except bit 0, which equals cin, and cout = 1.
- R5: Alternating-bit operands give the arithmetic sum. These are a of 0101... and b of 1010..., each pattern added to itself, and the two combined, each with cin 0 and 1.
- R6: With both operands zero, sum equals cin in bit 0 and zeros elsewhere, and cout is 0.
- R7: The outputs follow a change of the inputs without any clock edge. The block holds no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a    | input     | W     | First operand, unsigned |
| b    | input     | W     | Second operand, unsigned |
| cin  | input     | 1     | Carry into bit 0 |
| sum  | output    | W     | Low W bits of a + b + cin |
| cout | output    | 1     | Carry out of bit W-1 |

## Verification
The hardest case to reach is a carry that must be chosen by every selector in turn. Random operands produce this full propagate chain with vanishing probability at 32 and 64 bits. The stimulus therefore injects all-ones, zero and alternating-bit operands directly, and mixes them into the random stream every sixteenth vector. At 8 bits the exhaustive sweep visits every propagate and generate pattern at every slice boundary, including the one-bit final slice.

// File: rtl/sqcs_pkg.sv
package sqcs_pkg;

    // Nominal width of slice k: 2, 2, 3, 4, 5, ...
    function automatic int nominal_w(int k);
        return (k == 0) ? 2 : k + 1;
    endfunction

    // Least significant bit of slice k, clamped to the total width
    function automatic int grp_lsb(int w, int k);
        int s;
        s = 0;
        for (int j = 0; j < k; j++) s += nominal_w(j);
        return (s > w) ? w : s;
    endfunction

    // Actual width of slice k (last slice truncated)
    function automatic int grp_width(int w, int k);
        int l;
        int n;
        l = grp_lsb(w, k);
        n = nominal_w(k);
        return (l + n > w) ? (w - l) : n;
    endfunction

    // Number of slices needed to cover w bits
    function automatic int grp_count(int w);
        int c;
        c = 0;
        for (int k = 0; k < 64; k++)
            if (grp_lsb(w, k) < w) c = k + 1;
        return c;
    endfunction

endpackage

// File: rtl/sqcs_rca.sv
module sqcs_rca #(
    parameter int N = 4
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         ci,
    output logic [N-1:0] s,
    output logic         co
);
    logic [N:0] c;

    always_comb begin
        c[0] = ci;
        for (int i = 0; i < N; i++) begin
            s[i]   = a[i] ^ b[i] ^ c[i];
            c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
        end
        co = c[N];
    end
endmodule

// File: rtl/sqcs_bec.sv
module sqcs_bec #(
    parameter int N = 4
) (
    input  logic [N-1:0] x,
    output logic [N-1:0] y
);
    logic [N:0] run_and;

    always_comb begin
        run_and[0] = 1'b1;
        for (int i = 0; i < N; i++) begin
            y[i]         = x[i] ^ run_and[i];
            run_and[i+1] = run_and[i] & x[i];
        end
    end
endmodule

// File: rtl/sqcs_group.sv
module sqcs_group #(
    parameter int N = 4
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         sel,
    output logic [N-1:0] s,
    output logic         co
);
    logic [N-1:0] s_zero;
    logic         c_zero;
    logic [N:0]   plus_one;

    sqcs_rca #(.N(N)) u_rca (
        .a  (a),
        .b  (b),
        .ci (1'b0),
        .s  (s_zero),
        .co (c_zero)
    );

    sqcs_bec #(.N(N + 1)) u_bec (
        .x ({c_zero, s_zero}),
        .y (plus_one)
    );

    always_comb begin
        if (sel) begin
            s  = plus_one[N-1:0];
            co = plus_one[N];
        end else begin
            s  = s_zero;
            co = c_zero;
        end
    end
endmodule

// File: rtl/sqcs_adder.sv
module sqcs_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    import sqcs_pkg::*;

    localparam int G = grp_count(W);

    // gc[g] is the carry entering slice g
    logic [G:0] gc;

    assign gc[0] = cin;

    for (genvar g = 0; g < G; g++) begin : g_slice
        localparam int L  = grp_lsb(W, g);
        localparam int GW = grp_width(W, g);
        if (g == 0) begin : g_first
            sqcs_rca #(.N(GW)) u_rca (
                .a  (a[L+GW-1:L]),
                .b  (b[L+GW-1:L]),
                .ci (gc[g]),
                .s  (sum[L+GW-1:L]),
                .co (gc[g+1])
            );
        end else begin : g_sel
            sqcs_group #(.N(GW)) u_grp (
                .a   (a[L+GW-1:L]),
                .b   (b[L+GW-1:L]),
                .sel (gc[g]),
                .s   (sum[L+GW-1:L]),
                .co  (gc[g+1])
            );
        end
    end

    assign cout = gc[G];
endmodule

// File: rtl/sqcs_adder_chk.sv
module sqcs_adder_chk #(
    parameter int W = 32
) (
    input logic [W-1:0]                   a,
    input logic [W-1:0]                   b,
    input logic                           cin,
    input logic [W-1:0]                   sum,
    input logic                           cout,
    input logic [sqcs_pkg::grp_count(W):0] gc
);
    import sqcs_pkg::*;

    localparam int G = grp_count(W);

    logic [W:0] total;

    always_comb begin
        total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        AST_TOTAL_SUM: assert ({cout, sum} == total); // R1
    end

    for (genvar g = 0; g < G; g++) begin : g_chk
        localparam int L = grp_lsb(W, g);
        localparam int H = L + grp_width(W, g);
        logic [H:0] low;
        always_comb begin
            low = {1'b0, a[H-1:0]} + {1'b0, b[H-1:0]} + {{H{1'b0}}, cin};
            AST_SLICE_CARRY: assert (gc[g+1] == low[H]); // R2
            AST_SLICE_SUM: assert (sum[H-1:L] == low[H-1:L]); // R2
            AST_PROPAGATE_PASS: assert (!(&(a[H-1:L] ^ b[H-1:L])) || (gc[g+1] == gc[g])); // R3
        end
    end
endmodule

bind sqcs_adder sqcs_adder_chk #(.W(W)) u_chk (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .sum  (sum),
    .cout (cout),
    .gc   (gc)
);

// File: tb/sqcs_adder_test.sv
module sqcs_adder_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [7:0]  a8,  b8,  s8;   logic c8,  o8;
    logic [15:0] a16, b16, s16;  logic c16, o16;
    logic [31:0] a32, b32, s32;  logic c32, o32;
    logic [63:0] a64, b64, s64;  logic c64, o64;

    int nchecks = 0;
    int nerr    = 0;
    int cycles  = 0;
    bit done    = 0;

    sqcs_adder #(.W(8))  uut  (.a(a8),  .b(b8),  .cin(c8),  .sum(s8),  .cout(o8));
    sqcs_adder #(.W(16)) u16  (.a(a16), .b(b16), .cin(c16), .sum(s16), .cout(o16));
    sqcs_adder #(.W(32)) u32  (.a(a32), .b(b32), .cin(c32), .sum(s32), .cout(o32));
    sqcs_adder #(.W(64)) u64  (.a(a64), .b(b64), .cin(c64), .sum(s64), .cout(o64));

    task automatic chk(string r, logic [64:0] act, logic [64:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // Behavioural reference: plain integer addition
    task automatic check_all(string r8, string rbig);
        chk(r8,   {56'd0, o8,  s8},  {56'd0, 1'b0, a8}  + {57'd0, b8}  + {64'd0, c8});
        chk(rbig, {48'd0, o16, s16}, {48'd0, 1'b0, a16} + {49'd0, b16} + {64'd0, c16});
        chk(rbig, {32'd0, o32, s32}, {32'd0, 1'b0, a32} + {33'd0, b32} + {64'd0, c32});
        chk(rbig, {o64, s64},        {1'b0, a64}        + {1'b0, b64}  + {64'd0, c64});
    endtask

    task automatic drive(logic [63:0] x, logic [63:0] y, logic c);
        a8  = x[7:0];  b8  = y[7:0];  c8  = c;
        a16 = x[15:0]; b16 = y[15:0]; c16 = c;
        a32 = x[31:0]; b32 = y[31:0]; c32 = c;
        a64 = x;       b64 = y;       c64 = c;
    endtask

    task automatic step(logic [63:0] x, logic [63:0] y, logic c, string r);
        @(posedge clk);
        #1 drive(x, y, c);
        @(negedge clk);
        check_all(r, r);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 199000 && !done) begin
            done = 1;
            nerr++;
            nchecks++;
            $display("FAIL watchdog actual=%0d expected<199000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", nerr, nchecks);
            $finish;
        end
    end

    localparam logic [63:0] ONES = {64{1'b1}};
    localparam logic [63:0] ALT5 = {16{4'h5}};
    localparam logic [63:0] ALTA = {16{4'hA}};

    initial begin
        logic [63:0] rx, ry;
        drive(64'd0, 64'd0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R6 reset", "R6 reset");
        rst = 1'b0;

        step(64'd0, 64'd0, 1'b1, "R6");
        step(ONES, 64'd0, 1'b1, "R3");
        step(64'd0, ONES, 1'b1, "R3");
        step(ONES, ONES, 1'b0, "R4");
        step(ONES, ONES, 1'b1, "R4");
        for (int c = 0; c < 2; c++) begin
            step(ALT5, ALTA, c[0], "R5");
            step(ALT5, ALT5, c[0], "R5");
            step(ALTA, ALTA, c[0], "R5");
            step(ALTA, ALT5, c[0], "R5");
        end

        // R7: outputs change with no clock edge in between
        @(negedge clk);
        drive(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 1'b1);
        #1 check_all("R7", "R7");
        drive(ONES, 64'd1, 1'b0);
        #1 check_all("R7", "R7");

        // R1 exhaustive at 8 bits, R2 random at wider widths
        for (int i = 0; i < (1 << 17); i++) begin
            rx = {$urandom, $urandom};
            ry = {$urandom, $urandom};
            case (i % 16)
                3:  rx = ONES;
                7:  ry = ONES;
                11: begin rx = ALT5; ry = ALTA; end
                15: begin rx = ALTA; ry = ALTA; end
                default: ;
            endcase
            @(posedge clk);
            #1 begin
                drive(rx, ry, i[16]);
                a8 = i[15:8];
                b8 = i[7:0];
                c8 = i[16];
            end
            @(negedge clk);
            check_all("R1", "R2");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end
endmodule